// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block forms the data returned on a NOR flash read while an internal program or erase algorithm is running. While the array is busy it replaces array data with hardware sequence flags. These flags are a polarity flag on bit 7, a toggle flag on bit 6, a timeout-failure flag on bit 5, an erase-window flag on bit 3 and a sector-selective toggle flag on bit 2. Once the array is idle again, array data passes through unchanged.

Host reads are tracked from chip enable and output enable. A read cycle is complete when either enable goes high after both were low. The two toggle flags advance only when a read cycle completes. They do not advance if the bank address moved while both enables stayed low. A failure latch records a pulse-count overrun or an attempt to program a non-blank location. It keeps the status substitution in place until a reset command clears it. The command decoder and the algorithm sequencer supply the operating mode, the erase-window state and the failure events.

Top module: `flash_status_gen`

## Requirements
- R1: With mode idle (code 0) and no failure latched, `dq` equals `array_word`.
- R2: In program (1), erase (2) and suspend-program (4) modes, bit 6 of `dq` inverts after every completed read cycle, so two back-to-back reads differ in bit 6.
- R3: Bit 7 of `dq` is the inverse of `prog_bit7` in program and suspend-program modes. It is 0 in erase mode and 1 on a suspended-sector read in suspend-read mode (3).
- R4: In erase mode, bit 3 of `dq` is 0 while `erase_win_open` is high and 1 once it is low. In every other mode, status reads show bit 3 as 0.
- R5: In erase mode, bit 2 of `dq` inverts after a completed read only if `sector_hit` was high when that read started. Reads of other sectors leave it unchanged.
- R6: In suspend-read mode, reads with `sector_hit` high return status in which bit 2 inverts per completed read and bit 6 stays constant. Reads with `sector_hit` low return `array_word`.
- R7: In suspend-program mode, a read with `sector_hit` low shows bit 2 as 1.
- R8: A `pulse_over` or `prog_nonblank` pulse in any non-idle mode sets bit 5 of `dq` to 1 from the next clock. The flag then holds, even in idle mode, and status is still returned with bit 6 toggling and bit 7 the inverse of `prog_bit7`. A `reset_cmd` pulse clears it, and `reset_cmd` takes priority over a simultaneous failure event.
- R9: If `bank_addr` changes while `ce_n` and `oe_n` are both low, completing that read does not advance bit 6 or bit 2.
- R10: After `rst_n`, both toggle flags and the failure flag are 0. Bits 4, 1 and 0 of every status read are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| bank_addr | input | BANK_W | Bank part of the read address |
| sector_hit | input | 1 | Read address lies in the erasing or suspended sector |
| mode | input | 3 | Operating mode: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| erase_win_open | input | 1 | Additional-sector erase window still open |
| pulse_over | input | 1 | Internal pulse count exceeded, one-cycle event |
| prog_nonblank | input | 1 | Program attempted on a non-blank location, one-cycle event |
| reset_cmd | input | 1 | Reset command, clears the failure latch |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| array_word | input | DATA_W | Stored array data |
| dq | output | DATA_W | Read data or status flags |

## Verification
The end of a read cycle and the setting of the failure latch can both happen on the same clock edge. When they do, the toggle flag must advance and bit 5 must appear together on the following read. The bench raises output enable in the same cycle as a `pulse_over` pulse. It then expects the next read to show both the inverted bit 6 and bit 5 set. A later idle-mode read must still show status rather than array data.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE      = 3'd0,
        MODE_PROG      = 3'd1,
        MODE_ERASE     = 3'd2,
        MODE_SUSP_READ = 3'd3,
        MODE_SUSP_PROG = 3'd4
    } mode_e;
endpackage

// File: rtl/fsg_read_track.sv
module fsg_read_track #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [BANK_W-1:0] bank_addr,
    input  logic              sector_hit,
    output logic              read_end,
    output logic              read_ok,
    output logic              hit_lat
);
    typedef struct packed {
        logic              rd;
        logic              hit;
        logic              bad;
        logic [BANK_W-1:0] bank;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rd_now;

    always_comb begin
        rd_now = !ce_n && !oe_n;
        trk_d  = trk_q;
        trk_d.rd = rd_now;
        if (rd_now && !trk_q.rd) begin
            trk_d.hit  = sector_hit;
            trk_d.bank = bank_addr;
            trk_d.bad  = 1'b0;
        end else if (rd_now && trk_q.rd && (bank_addr != trk_q.bank)) begin
            trk_d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign read_end = trk_q.rd && !rd_now;
    assign read_ok  = !trk_q.bad;
    assign hit_lat  = trk_q.hit;

    // R9: an address move inside an open read marks it as not counting
    p_bank_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && trk_q.rd && (bank_addr != trk_q.bank)) |=> !read_ok);
endmodule

// File: rtl/fsg_flag_state.sv
module fsg_flag_state
    import fsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  read_end,
    input  logic  read_ok,
    input  logic  hit_lat,
    input  logic  pulse_over,
    input  logic  prog_nonblank,
    input  logic  reset_cmd,
    output logic  tog6,
    output logic  tog2,
    output logic  fail
);
    typedef struct packed {
        logic t6;
        logic t2;
        logic fail;
    } flg_t;

    flg_t flg_d, flg_q;
    logic adv, en6, en2;

    always_comb begin
        adv = read_end && read_ok;
        en6 = (mode == MODE_PROG) || (mode == MODE_ERASE) ||
              (mode == MODE_SUSP_PROG) || flg_q.fail;
        en2 = hit_lat && ((mode == MODE_ERASE) || (mode == MODE_SUSP_READ) ||
                          (mode == MODE_SUSP_PROG));
        flg_d = flg_q;
        if (adv && en6) flg_d.t6 = !flg_q.t6;
        if (adv && en2) flg_d.t2 = !flg_q.t2;
        if (reset_cmd)
            flg_d.fail = 1'b0;
        else if ((mode != MODE_IDLE) && (pulse_over || prog_nonblank))
            flg_d.fail = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign tog6 = flg_q.t6;
    assign tog2 = flg_q.t2;
    assign fail = flg_q.fail;

    // R8: failure persists until a reset command
    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !reset_cmd) |=> fail);
    // R8: reset command always clears
    p_fail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> !fail);
    // R2: completed read in program mode flips the bit 6 state
    p_prog_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (read_end && read_ok && mode == MODE_PROG) |=> (tog6 != $past(tog6)));
    // R6: suspend-read keeps bit 6 frozen
    p_susp_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SUSP_READ && !fail) |=> $stable(tog6));
endmodule

// File: rtl/fsg_out_mux.sv
module fsg_out_mux
    import fsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  mode_e             mode,
    input  logic              tog6,
    input  logic              tog2,
    input  logic              fail,
    input  logic              sector_hit,
    input  logic              erase_win_open,
    input  logic              prog_bit7,
    input  logic [DATA_W-1:0] array_word,
    output logic [DATA_W-1:0] dq
);
    localparam int POS_POLL  = 7;
    localparam int POS_TOG   = 6;
    localparam int POS_FAIL  = 5;
    localparam int POS_WIN   = 3;
    localparam int POS_SECT  = 2;

    logic pass;
    logic [DATA_W-1:0] sts;

    always_comb begin
        pass = ((mode == MODE_IDLE) && !fail) ||
               ((mode == MODE_SUSP_READ) && !sector_hit && !fail);
        sts = '0;
        case (mode)
            MODE_ERASE:     sts[POS_POLL] = 1'b0;
            MODE_SUSP_READ: sts[POS_POLL] = 1'b1;
            default:        sts[POS_POLL] = !prog_bit7;
        endcase
        sts[POS_TOG]  = tog6;
        sts[POS_FAIL] = fail;
        sts[POS_WIN]  = (mode == MODE_ERASE) && !erase_win_open;
        sts[POS_SECT] = ((mode == MODE_SUSP_PROG) && !sector_hit) ? 1'b1 : tog2;
        dq = pass ? array_word : sts;
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [BANK_W-1:0] bank_addr,
    input  logic              sector_hit,
    input  mode_e             mode,
    input  logic              erase_win_open,
    input  logic              pulse_over,
    input  logic              prog_nonblank,
    input  logic              reset_cmd,
    input  logic              prog_bit7,
    input  logic [DATA_W-1:0] array_word,
    output logic [DATA_W-1:0] dq
);
    logic read_end, read_ok, hit_lat;
    logic tog6, tog2, fail;

    fsg_read_track #(.BANK_W(BANK_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .bank_addr(bank_addr), .sector_hit(sector_hit),
        .read_end(read_end), .read_ok(read_ok), .hit_lat(hit_lat)
    );

    fsg_flag_state u_flg (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .read_end(read_end), .read_ok(read_ok), .hit_lat(hit_lat),
        .pulse_over(pulse_over), .prog_nonblank(prog_nonblank),
        .reset_cmd(reset_cmd), .tog6(tog6), .tog2(tog2), .fail(fail)
    );

    fsg_out_mux #(.DATA_W(DATA_W)) u_mux (
        .mode(mode), .tog6(tog6), .tog2(tog2), .fail(fail),
        .sector_hit(sector_hit), .erase_win_open(erase_win_open),
        .prog_bit7(prog_bit7), .array_word(array_word), .dq(dq)
    );

    // R9: a read spoiled by an address move leaves both toggle states alone
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (read_end && !read_ok) |=> ($stable(tog6) && $stable(tog2)));
    // R5: erase-mode reads of other sectors never move bit 2
    p_sect_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (read_end && !hit_lat && mode == MODE_ERASE) |=> $stable(tog2));
endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
    import fsg_pkg::*;

    typedef struct packed {
        mode_e      mode;
        logic       hit;
        logic       win;
        logic       pb7;
        logic [7:0] arr;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // Rows assume toggle states start at 0 after reset.
    localparam vec_t TBL [15] = '{
        '{MODE_IDLE,      1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 4'd1},  // R1
        '{MODE_PROG,      1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 4'd2},  // R2
        '{MODE_PROG,      1'b0, 1'b0, 1'b1, 8'h00, 8'h40, 4'd2},  // R2
        '{MODE_PROG,      1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 4'd3},  // R3
        '{MODE_ERASE,     1'b1, 1'b1, 1'b0, 8'h00, 8'h40, 4'd4},  // R4
        '{MODE_ERASE,     1'b1, 1'b0, 1'b0, 8'h00, 8'h0C, 4'd5},  // R5
        '{MODE_ERASE,     1'b0, 1'b0, 1'b0, 8'h00, 8'h48, 4'd5},  // R5
        '{MODE_ERASE,     1'b0, 1'b0, 1'b0, 8'h00, 8'h08, 4'd5},  // R5
        '{MODE_SUSP_READ, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC0, 4'd6},  // R6
        '{MODE_SUSP_READ, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC4, 4'd6},  // R6
        '{MODE_SUSP_READ, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 4'd6},  // R6
        '{MODE_SUSP_PROG, 1'b0, 1'b0, 1'b1, 8'h00, 8'h44, 4'd7},  // R7
        '{MODE_SUSP_PROG, 1'b0, 1'b0, 1'b1, 8'h00, 8'h04, 4'd7},  // R7
        '{MODE_SUSP_PROG, 1'b1, 1'b0, 1'b1, 8'h00, 8'h40, 4'd3},  // R3
        '{MODE_IDLE,      1'b0, 1'b0, 1'b0, 8'h5A, 8'h5A, 4'd1}   // R1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1;
    logic [1:0] bank_addr = '0;
    logic       sector_hit = 1'b0;
    mode_e      mode = MODE_IDLE;
    logic       erase_win_open = 1'b0;
    logic       pulse_over = 1'b0, prog_nonblank = 1'b0, reset_cmd = 1'b0;
    logic       prog_bit7 = 1'b0;
    logic [7:0] array_word = '0;
    logic [7:0] dq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = !clk;

    flash_status_gen i_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .bank_addr(bank_addr), .sector_hit(sector_hit), .mode(mode),
        .erase_win_open(erase_win_open), .pulse_over(pulse_over),
        .prog_nonblank(prog_nonblank), .reset_cmd(reset_cmd),
        .prog_bit7(prog_bit7), .array_word(array_word), .dq(dq)
    );

    task automatic check(input logic [7:0] exp, input string tag);
        n_chk++;
        if (dq !== exp) begin
            n_bad++;
            $display("FAIL %s: dq=%02h expected %02h", tag, dq, exp);
        end
    endtask

    // one full read: open, sample mid-cycle, close (toggle advances at close)
    task automatic do_read(input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
        oe_n = 1'b1; ce_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic pulse_cmd(input int which);
        @(posedge clk); #1;
        if (which == 0) pulse_over = 1'b1;
        else if (which == 1) prog_nonblank = 1'b1;
        else reset_cmd = 1'b1;
        @(posedge clk); #1;
        pulse_over = 1'b0; prog_nonblank = 1'b0; reset_cmd = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        foreach (TBL[i]) begin
            mode = TBL[i].mode;
            sector_hit = TBL[i].hit;
            erase_win_open = TBL[i].win;
            prog_bit7 = TBL[i].pb7;
            array_word = TBL[i].arr;
            do_read(TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i));
        end
        // now: bit6 state 0, bit2 state 1, no failure

        // R9: bank moves while both enables stay low -> no advance
        mode = MODE_PROG; prog_bit7 = 1'b1; sector_hit = 1'b0; bank_addr = 2'd0;
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk); #1;
        bank_addr = 2'd1;
        @(posedge clk);
        @(negedge clk);
        check(8'h04, "R9 spoiled read");
        oe_n = 1'b1; ce_n = 1'b1;
        @(posedge clk); #1;
        do_read(8'h04, "R9 bit6 unchanged");   // bit6 state now 1

        // R8 + R2 same edge: read close coincides with pulse_over
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(8'h44, "R2 before fail");
        oe_n = 1'b1; ce_n = 1'b1; pulse_over = 1'b1;
        @(posedge clk); #1;
        pulse_over = 1'b0;
        do_read(8'h24, "R8 fail and toggle together");
        mode = MODE_IDLE; array_word = 8'h5A;
        do_read(8'h64, "R8 status held in idle");
        pulse_cmd(2);
        do_read(8'h5A, "R8 cleared by reset command");

        // R8: non-blank program lockout, bit6 state 0 here
        mode = MODE_PROG; prog_bit7 = 1'b1;
        pulse_cmd(1);
        do_read(8'h24, "R8 nonblank lockout");
        // R8: reset command wins over a simultaneous failure event
        @(posedge clk); #1;
        reset_cmd = 1'b1; pulse_over = 1'b1;
        @(posedge clk); #1;
        reset_cmd = 1'b0; pulse_over = 1'b0;
        mode = MODE_IDLE; array_word = 8'hC3;
        do_read(8'hC3, "R8 reset priority");

        // R10: hardware reset clears toggle and failure state
        mode = MODE_PROG;
        pulse_cmd(0);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        prog_bit7 = 1'b1;
        do_read(8'h00, "R10 reset state");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule